// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block sits on the downstream side of a host bridge and decides whether a memory request should be forwarded to a PCI Express port. It holds two programmable address windows. The first is a plain memory window that lies below 4 GB. The second is a prefetchable window whose bounds can reach above 4 GB. Each window is set in 1 MB units by a base register and a limit register. A command register carries a single enable bit that gates both windows.

The block also holds two DRAM boundaries: the top of low DRAM, used for addresses under 4 GB, and the top of upper DRAM, used for addresses at or above 4 GB. A request that hits a window but falls below the boundary that applies to it is not forwarded. It is reported as a DRAM conflict instead.

Software programs the registers through a simple write port and a combinational read port. Requests arrive as a 64-bit address with a valid strobe. The three result flags are registered.

Top module: `mem_window_decoder`

## Requirements
- R1: Register map, indexed by `reg_addr_i`. Index 0 is the command register; only bit 0 (memory enable) is kept. Indices 1 and 2 are the plain window base and limit. Indices 3 and 4 are the prefetchable window base and limit. Index 7 is the top of low DRAM. Index 8 is the lower word of the top of upper DRAM. For indices 1, 2, 3, 4, 7 and 8, only bits 31:20 are kept; they hold address bits 31:20. Indices 5 and 6 hold address bits 63:32 of the prefetchable base and limit. Index 9 holds bits 63:32 of the top of upper DRAM. Bits that are not kept read back as zero, and unmapped indices read as zero.
- R2: A window base has address bits 19:0 implied as zero. A limit has address bits 19:0 implied as all ones. Windows therefore start and end on 1 MB boundaries.
- R3: A window matches when base <= address <= limit. Both ends are included.
- R4: `hit_o` is set when the request matches either window, memory enable is set, and no DRAM conflict applies.
- R5: While memory enable is 0, `hit_o`, `pf_o` and `conflict_o` all stay 0 for every request.
- R6: `pf_o` is set exactly when `hit_o` is set and the address lies in the prefetchable window.
- R7: The upper bits of the prefetchable window come from indices 5 and 6, so that window can sit above 4 GB. The plain window always has address bits 63:32 equal to zero.
- R8: `conflict_o` is set, and `hit_o` is cleared, when the request matches an enabled window and its address is below the applicable boundary. That boundary is the top of low DRAM for addresses under 4 GB and the top of upper DRAM (bits 19:0 zero) otherwise.
- R9: A window whose limit is below its base never matches.
- R10: The flags appear on the clock edge that samples `req_valid_i` high and are all 0 after a cycle without a valid request. A register write in the same cycle as a request affects only later requests.
- R11: After reset every register reads 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| req_valid_i | input | 1 | Request address valid |
| req_addr_i | input | 64 | Request byte address |
| hit_o | output | 1 | Forward request downstream |
| pf_o | output | 1 | Forwarded request is in the prefetchable (write-combining) window |
| conflict_o | output | 1 | Request matched a window but overlaps DRAM |

## Verification
All three flags are due on the first rising edge after the cycle in which `req_valid_i` was driven. The bench drives requests on the falling edge and predicts the flags at the next rising edge, using register values from before that edge's write. It then compares them on the following falling edge. Read data is combinational, so each readback is compared shortly after `reg_addr_i` changes, inside the same cycle. Directed probes at window ends, at 1 MB edges and at the 4 GB split are checked against fixed expected values, in the cycle after the probe.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_CMD       = 4'd0,
    RA_NP_BASE   = 4'd1,
    RA_NP_LIMIT  = 4'd2,
    RA_PF_BASE   = 4'd3,
    RA_PF_LIMIT  = 4'd4,
    RA_PF_BASE_H = 4'd5,
    RA_PF_LIM_H  = 4'd6,
    RA_LOW_TOP   = 4'd7,
    RA_UP_TOP    = 4'd8,
    RA_UP_TOP_H  = 4'd9
  } reg_idx_e;

  localparam int NUM_WIN = 2;
  localparam int WIN_NP  = 0;
  localparam int WIN_PF  = 1;
endpackage

// File: rtl/mwd_regfile.sv
module mwd_regfile
  import mwd_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 32,
  parameter int GRAN_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] idx_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              mem_en_o,
  output logic [ADDR_W-1:0] np_lo_o,
  output logic [ADDR_W-1:0] np_hi_o,
  output logic [ADDR_W-1:0] pf_lo_o,
  output logic [ADDR_W-1:0] pf_hi_o,
  output logic [ADDR_W-1:0] low_top_o,
  output logic [ADDR_W-1:0] up_top_o
);
  localparam int FLD_W = REG_W - GRAN_W;
  localparam int HI_W  = ADDR_W - REG_W;

  logic             mem_en_q;
  logic [FLD_W-1:0] np_base_q, np_lim_q, pf_base_q, pf_lim_q, low_top_q, up_top_q;
  logic [HI_W-1:0]  pf_base_h_q, pf_lim_h_q, up_top_h_q;

  logic [FLD_W-1:0] wfld;
  assign wfld = wdata_i[REG_W-1:GRAN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_en_q    <= 1'b0;
      np_base_q   <= '0;
      np_lim_q    <= '0;
      pf_base_q   <= '0;
      pf_lim_q    <= '0;
      low_top_q   <= '0;
      up_top_q    <= '0;
      pf_base_h_q <= '0;
      pf_lim_h_q  <= '0;
      up_top_h_q  <= '0;
    end else if (we_i) begin
      case (idx_i)
        RA_CMD:       mem_en_q    <= wdata_i[0];
        RA_NP_BASE:   np_base_q   <= wfld;
        RA_NP_LIMIT:  np_lim_q    <= wfld;
        RA_PF_BASE:   pf_base_q   <= wfld;
        RA_PF_LIMIT:  pf_lim_q    <= wfld;
        RA_PF_BASE_H: pf_base_h_q <= HI_W'(wdata_i);
        RA_PF_LIM_H:  pf_lim_h_q  <= HI_W'(wdata_i);
        RA_LOW_TOP:   low_top_q   <= wfld;
        RA_UP_TOP:    up_top_q    <= wfld;
        RA_UP_TOP_H:  up_top_h_q  <= HI_W'(wdata_i);
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      RA_CMD:       rdata_o = {{(REG_W-1){1'b0}}, mem_en_q};
      RA_NP_BASE:   rdata_o = {np_base_q, {GRAN_W{1'b0}}};
      RA_NP_LIMIT:  rdata_o = {np_lim_q, {GRAN_W{1'b0}}};
      RA_PF_BASE:   rdata_o = {pf_base_q, {GRAN_W{1'b0}}};
      RA_PF_LIMIT:  rdata_o = {pf_lim_q, {GRAN_W{1'b0}}};
      RA_PF_BASE_H: rdata_o = REG_W'(pf_base_h_q);
      RA_PF_LIM_H:  rdata_o = REG_W'(pf_lim_h_q);
      RA_LOW_TOP:   rdata_o = {low_top_q, {GRAN_W{1'b0}}};
      RA_UP_TOP:    rdata_o = {up_top_q, {GRAN_W{1'b0}}};
      RA_UP_TOP_H:  rdata_o = REG_W'(up_top_h_q);
      default:      rdata_o = '0;
    endcase
  end

  // Expand 1 MB fields to byte addresses: base low bits zero, limit low bits ones
  assign mem_en_o  = mem_en_q;
  assign np_lo_o   = {{HI_W{1'b0}}, np_base_q, {GRAN_W{1'b0}}};
  assign np_hi_o   = {{HI_W{1'b0}}, np_lim_q,  {GRAN_W{1'b1}}};
  assign pf_lo_o   = {pf_base_h_q, pf_base_q, {GRAN_W{1'b0}}};
  assign pf_hi_o   = {pf_lim_h_q,  pf_lim_q,  {GRAN_W{1'b1}}};
  assign low_top_o = {{HI_W{1'b0}}, low_top_q, {GRAN_W{1'b0}}};
  assign up_top_o  = {up_top_h_q, up_top_q, {GRAN_W{1'b0}}};
endmodule

// File: rtl/mwd_window.sv
module mwd_window #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic              match_o
);
  // Inclusive on both ends; an inverted window matches nothing
  assign match_o = (addr_i >= lo_i) && (addr_i <= hi_i);
endmodule

// File: rtl/mwd_dram_guard.sv
module mwd_dram_guard #(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] low_top_i,
  input  logic [ADDR_W-1:0] up_top_i,
  output logic              in_dram_o
);
  logic above_4g;
  assign above_4g  = |addr_i[ADDR_W-1:REG_W];
  assign in_dram_o = above_4g ? (addr_i < up_top_i) : (addr_i < low_top_i);
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import mwd_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 32,
  parameter int GRAN_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              hit_o,
  output logic              pf_o,
  output logic              conflict_o
);
  logic              mem_en;
  logic [ADDR_W-1:0] win_lo [NUM_WIN];
  logic [ADDR_W-1:0] win_hi [NUM_WIN];
  logic [NUM_WIN-1:0] win_match;
  logic [ADDR_W-1:0] low_top, up_top;
  logic              in_dram;

  mwd_regfile #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .GRAN_W(GRAN_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .idx_i     (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .mem_en_o  (mem_en),
    .np_lo_o   (win_lo[WIN_NP]),
    .np_hi_o   (win_hi[WIN_NP]),
    .pf_lo_o   (win_lo[WIN_PF]),
    .pf_hi_o   (win_hi[WIN_PF]),
    .low_top_o (low_top),
    .up_top_o  (up_top)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    mwd_window #(.ADDR_W(ADDR_W)) u_win (
      .addr_i  (req_addr_i),
      .lo_i    (win_lo[g]),
      .hi_i    (win_hi[g]),
      .match_o (win_match[g])
    );
  end

  mwd_dram_guard #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_guard (
    .addr_i    (req_addr_i),
    .low_top_i (low_top),
    .up_top_i  (up_top),
    .in_dram_o (in_dram)
  );

  logic claim;
  assign claim = req_valid_i && mem_en && (|win_match);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o      <= 1'b0;
      pf_o       <= 1'b0;
      conflict_o <= 1'b0;
    end else begin
      hit_o      <= claim && !in_dram;
      pf_o       <= claim && !in_dram && win_match[WIN_PF];
      conflict_o <= claim && in_dram;
    end
  end
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic mem_en_i,
  input logic hit_o,
  input logic pf_o,
  input logic conflict_o
);
  a_r8_no_hit_on_conflict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && conflict_o));

  a_r6_pf_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_o |-> hit_o);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!hit_o && !pf_o && !conflict_o));

  a_r5_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_en_i |=> (!hit_o && !pf_o && !conflict_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r11_reset_clear: assert (!hit_o && !pf_o && !conflict_o);
    end
  end
endmodule

bind mem_window_decoder mwd_checker u_mwd_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .mem_en_i    (mem_en),
  .hit_o       (hit_o),
  .pf_o        (pf_o),
  .conflict_o  (conflict_o)
);

// File: tb/mem_window_decoder_bench.sv
module mem_window_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_addr_i = '0;
  logic        hit_o, pf_o, conflict_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  mem_window_decoder u_mem_window_decoder (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .req_valid_i, .req_addr_i, .hit_o, .pf_o, .conflict_o
  );

  // ---------------- reference model ----------------
  longint unsigned mr [10];
  typedef struct { bit h; bit p; bit c; } flags_t;
  flags_t exp_q [$];

  function automatic longint unsigned keep_mask(int i);
    case (i)
      0:       return 64'h1;
      5, 6, 9: return 64'hFFFF_FFFF;
      default: return 64'hFFF0_0000;
    endcase
  endfunction

  function automatic flags_t predict(longint unsigned a);
    flags_t f;
    longint unsigned nb, nl, pb, pl, lt, ut;
    bit in_np, in_pf, below;
    nb = mr[1];
    nl = mr[2] | 64'hF_FFFF;
    pb = (mr[5] << 32) | mr[3];
    pl = (mr[6] << 32) | mr[4] | 64'hF_FFFF;
    lt = mr[7];
    ut = (mr[9] << 32) | mr[8];
    in_np = (a >= nb) && (a <= nl);
    in_pf = (a >= pb) && (a <= pl);
    below = (a < 64'h1_0000_0000) ? (a < lt) : (a < ut);
    f.h = mr[0][0] && (in_np || in_pf) && !below;
    f.p = f.h && in_pf;
    f.c = mr[0][0] && (in_np || in_pf) && below;
    return f;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 10; i++) mr[i] = 0;
      exp_q.delete();
    end else begin
      flags_t f;
      if (req_valid_i) f = predict(req_addr_i);
      else begin f.h = 0; f.p = 0; f.c = 0; end
      exp_q.push_back(f);
      if (reg_we_i && reg_addr_i < 10)
        mr[reg_addr_i] = longint'(reg_wdata_i) & keep_mask(int'(reg_addr_i));
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && exp_q.size() > 0) begin
      flags_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (hit_o !== e.h) begin n_bad++; $display("FAIL R4 hit_o got %0b exp %0b", hit_o, e.h); end
      n_chk++;
      if (pf_o !== e.p) begin n_bad++; $display("FAIL R6 pf_o got %0b exp %0b", pf_o, e.p); end
      n_chk++;
      if (conflict_o !== e.c) begin n_bad++; $display("FAIL R8 conflict_o got %0b exp %0b", conflict_o, e.c); end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 4'(idx); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    reg_addr_i = 4'(idx);
    #1;
    chk(64'(reg_rdata_o), 64'(exp), tag);
  endtask

  task automatic probe(input logic [63:0] a, input bit eh, input bit ep, input bit ec,
                       input string tag);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(64'({hit_o, pf_o, conflict_o}), 64'({eh, ep, ec}), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(64'({hit_o, pf_o, conflict_o}), 64'd0, "R11 flags in reset");
    rst_ni = 1'b1;
    for (int i = 0; i < 10; i++) rd(i, 32'h0, "R11 register clear");

    // R1 kept bits and readback
    wr(1, 32'hFFFF_FFFF); rd(1, 32'hFFF0_0000, "R1 base low bits read zero");
    wr(0, 32'hFFFF_FFFE); rd(0, 32'h0, "R1 command keeps bit 0 only");
    wr(5, 32'hDEAD_BEEF); rd(5, 32'hDEAD_BEEF, "R1 upper base full width");
    wr(12, 32'hFFFF_FFFF); rd(12, 32'h0, "R1 unmapped index");
    wr(5, 32'h0);

    // Boundaries and windows
    wr(7, 32'h4000_0000);   // low DRAM top 1 GB
    wr(9, 32'h2);           // upper DRAM top 8 GB
    wr(8, 32'h0);
    wr(1, 32'h8000_0000);
    wr(2, 32'h80F0_0000);   // plain window 0x8000_0000..0x80FF_FFFF
    wr(0, 32'h1);

    probe(64'h8000_0000, 1, 0, 0, "R3 base inclusive");
    probe(64'h7FFF_FFFF, 0, 0, 0, "R3 below base");
    probe(64'h80FF_FFFF, 1, 0, 0, "R2 limit implied ones");
    probe(64'h8100_0000, 0, 0, 0, "R2 past limit");
    probe(64'h1_8000_0000, 0, 0, 0, "R7 plain window under 4 GB only");

    wr(3, 32'h0); wr(5, 32'h3);
    wr(4, 32'h0010_0000); wr(6, 32'h3);  // 0x3_0000_0000..0x3_001F_FFFF
    probe(64'h3_0000_0000, 1, 1, 0, "R7 prefetchable above 4 GB");
    probe(64'h3_001F_FFFF, 1, 1, 0, "R6 prefetchable at limit");
    probe(64'h3_0020_0000, 0, 0, 0, "R6 past prefetchable limit");

    wr(9, 32'h4);  // upper DRAM top 16 GB overlaps window
    probe(64'h3_0000_0000, 0, 0, 1, "R8 upper DRAM conflict");
    wr(9, 32'h2);
    wr(1, 32'h3000_0000); wr(2, 32'h3000_0000);
    probe(64'h3000_1000, 0, 0, 1, "R8 low DRAM conflict");
    wr(1, 32'h8000_0000); wr(2, 32'h80F0_0000);

    // R10 same-cycle write sees old enable
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 4'd0; reg_wdata_i = 32'h0;
    req_valid_i = 1'b1; req_addr_i = 64'h8000_0000;
    @(negedge clk_i);
    reg_we_i = 1'b0; req_valid_i = 1'b0;
    chk(64'(hit_o), 64'd1, "R10 write applies after request");
    @(negedge clk_i);
    chk(64'({hit_o, pf_o, conflict_o}), 64'd0, "R10 idle cycle flags zero");

    probe(64'h8000_0000, 0, 0, 0, "R5 disabled plain window");
    probe(64'h3_0000_0000, 0, 0, 0, "R5 disabled prefetchable window");
    wr(1, 32'h3000_0000); wr(2, 32'h3000_0000);
    probe(64'h3000_1000, 0, 0, 0, "R5 disabled no conflict");
    wr(0, 32'h1);

    wr(1, 32'h9000_0000); wr(2, 32'h8000_0000);
    probe(64'h8800_0000, 0, 0, 0, "R9 inverted window mid");
    probe(64'h9000_0000, 0, 0, 0, "R9 inverted window base");
    probe(64'h800F_FFFF, 0, 0, 0, "R9 inverted window limit");

    // Mixed traffic, compared every clock by the model
    for (int k = 0; k < 600; k++) begin
      @(negedge clk_i);
      if ($urandom_range(0, 7) == 0) begin
        reg_we_i = 1'b1;
        reg_addr_i = 4'($urandom_range(0, 9));
        reg_wdata_i = $urandom_range(0, 3) == 0 ? 32'h1 : {$urandom_range(0, 15), 28'h0};
        if (reg_addr_i inside {4'd5, 4'd6, 4'd9}) reg_wdata_i = $urandom_range(0, 4);
      end else reg_we_i = 1'b0;
      req_valid_i = 1'($urandom_range(0, 1));
      req_addr_i = {32'($urandom_range(0, 4)), 4'($urandom_range(0, 15)),
                    8'($urandom_range(0, 1) ? 8'h00 : 8'hFF), 20'($urandom)};
    end
    @(negedge clk_i);
    reg_we_i = 1'b0; req_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule